// File: doc/BRIEF.md
# DMA Descriptor Queue Front-End

This block sits on the register side of a stream-to-memory DMA channel. Software hands the channel empty buffers by posting 72-bit descriptors into an available queue. Each descriptor names a buffer index, a byte count and a 40-bit bus address. The block offers the head of that queue to a write engine over a valid/ready handshake. The engine returns one completion record per filled buffer over a second valid/ready handshake, and software drains these records through a three-word read window.

A descriptor crosses the 32-bit register bus as three writes. Only the write of the top word commits the entry to the queue, so software never exposes a half-built descriptor. On the read side, the read of the top word pops the record.

A loop mode lets the channel run without software refilling it. Every accepted completion is also turned back into a fresh descriptor. That descriptor keeps the same index and address and uses the byte count that software first posted for that index. It goes into the available queue again.

Both streams follow the usual valid/ready rules. A transfer happens on a clock edge where both valid and ready are high. The descriptor output keeps valid high and its data unchanged while ready is low, unless software changes the control register. The completion input is refused, with ready low, while the completion queue is full or the channel is held.

Top module: `dma_desc_frontend`

## Requirements
- R1: The control register at offset 0x00 resets to 0x7. While any of its bits [2:0] is set, the channel is held. On each clock edge in that state both queues are emptied and the overflow flag is cleared. While held, the descriptor output is not valid, completion input is not ready, and `engine_en` is low. Bits [2:0] and bit 8 read back at offset 0x00.
- R2: A descriptor is 72 bits. Word 0 holds the index in [8:0] and the byte count in [31:9]. Word 1 holds address bits [31:0]. Word 2 holds address bits [39:32] in [7:0]. Writes to 0x20 and 0x24 only stage words 0 and 1. A write to 0x28 commits the three words as one entry on the following clock edge. The entry appears in the 72-bit data as {address, count, index}.
- R3: A commit or recirculation into a full available queue is dropped. It sets a sticky overflow flag, read at bit 1 of offset 0x1C. The flag is cleared only by reset or by holding the channel.
- R4: `dsc_valid` is high exactly when bit 8 of the control register is set, the channel is not held, and the available queue is not empty. Descriptors leave in queue order, one per edge with `dsc_ready` high.
- R5: A completion is accepted on an edge with both `cpl_valid` and `cpl_ready` high. `cpl_ready` is low while the completion queue holds its full depth or while the channel is held.
- R6: Reads of 0x20, 0x24 and 0x28 return words 0, 1 and 2 of the oldest completion record, or zero when none is queued. A read of 0x28 pops that record. Reading 0x28 with the queue empty changes nothing.
- R7: Offset 0x18 reads the number of entries in the available queue. Offset 0x10 reads the number of completion records. Bit 0 of 0x1C is high when the completion queue is empty.
- R8: With bit 0 at offset 0x04 set, each accepted completion is stored as a record and also pushed back into the available queue. The recycled descriptor has the completion's index, the completion's address, and the count posted by software for that index. The count field of the completion is ignored for this purpose.
- R9: When a recirculation and a software commit fall on the same edge, the recirculated entry enters the queue first. The software entry follows on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x28 pops a record |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd`, zero otherwise |
| engine_en | output | 1 | Engine enabled and channel not held |
| dsc_valid | output | 1 | Descriptor offered to the write engine |
| dsc_ready | input | 1 | Write engine takes the descriptor |
| dsc_data | output | 72 | Descriptor {address, count, index} |
| cpl_valid | input | 1 | Completion record offered by the write engine |
| cpl_ready | output | 1 | Front-end accepts the completion |
| cpl_data | input | 72 | Completion {address, transferred count, index} |

## Verification
The hardest case is a loop-mode recirculation that lands on the same edge as a pending software commit. This case is R9. To reach it, the bench writes the top descriptor word in one cycle and raises `cpl_valid` in the next cycle, with the channel released and loop mode on. The write engine is then stalled, so the order of the two entries shows up at the descriptor output. The overflow flag and full completion queue are reached on a shrunken queue depth. Once the engine is enabled, that flag is checked to stay set while the queue drains.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int IDX_W   = 9;
  localparam int CNT_W   = 23;
  localparam int BADR_W  = 40;
  localparam int DESC_W  = IDX_W + CNT_W + BADR_W;
  localparam int REG_AW  = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_LOOP  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_CPLN  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_FREE  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_FLAGS = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_WIN0  = 8'h20;
  localparam logic [REG_AW-1:0] OFS_WIN1  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_WIN2  = 8'h28;

  localparam int CTRL_RUN_BIT = 8;

  typedef struct packed {
    logic [BADR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
  } desc_t;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
  parameter int W  = 72,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   count
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == DEPTH[AW:0]);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/dmaq_csr.sv
module dmaq_csr
  import dmaq_pkg::*;
#(
  parameter int QAW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              loop_push,
  input  desc_t             cpl_head,
  input  logic              cpl_empty,
  input  logic [QAW:0]      cpl_cnt,
  input  logic [QAW:0]      avail_cnt,
  input  logic              ovf,
  output logic              hold,
  output logic              run,
  output logic              loop_en,
  output desc_t             sw_desc,
  output logic              sw_commit,
  output logic              win_pop
);
  logic [2:0]  rstb_q;
  logic        run_q, loop_q, pend_q;
  logic [31:0] w0_q, w1_q;
  desc_t       pend_d_q;
  logic        wr_ctrl, wr_loop, wr_w0, wr_w1, wr_w2;

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_loop = reg_wr && (reg_addr == OFS_LOOP);
  assign wr_w0   = reg_wr && (reg_addr == OFS_WIN0);
  assign wr_w1   = reg_wr && (reg_addr == OFS_WIN1);
  assign wr_w2   = reg_wr && (reg_addr == OFS_WIN2);

  assign hold    = |rstb_q;
  assign run     = run_q && !hold;
  assign loop_en = loop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstb_q   <= 3'b111;
      run_q    <= 1'b0;
      loop_q   <= 1'b0;
      pend_q   <= 1'b0;
      w0_q     <= '0;
      w1_q     <= '0;
      pend_d_q <= '0;
    end else begin
      if (wr_ctrl) begin
        rstb_q <= reg_wdata[2:0];
        run_q  <= reg_wdata[CTRL_RUN_BIT];
      end
      if (wr_loop) loop_q <= reg_wdata[0];
      if (wr_w0)   w0_q   <= reg_wdata;
      if (wr_w1)   w1_q   <= reg_wdata;
      if (wr_w2)   pend_d_q <= desc_t'({reg_wdata[BADR_W-33:0], w1_q, w0_q});
      pend_q <= !hold && (wr_w2 || (pend_q && loop_push));
    end
  end

  assign sw_desc   = pend_d_q;
  assign sw_commit = pend_q && !loop_push && !hold;
  assign win_pop   = reg_rd && (reg_addr == OFS_WIN2) && !cpl_empty && !hold;

  logic [DESC_W-1:0] head_bits;
  assign head_bits = cpl_empty ? '0 : cpl_head;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL:  reg_rdata = {23'd0, run_q, 5'd0, rstb_q};
        OFS_LOOP:  reg_rdata = {31'd0, loop_q};
        OFS_CPLN:  reg_rdata = {{(31-QAW){1'b0}}, cpl_cnt};
        OFS_FREE:  reg_rdata = {{(31-QAW){1'b0}}, avail_cnt};
        OFS_FLAGS: reg_rdata = {30'd0, ovf, cpl_empty};
        OFS_WIN0:  reg_rdata = head_bits[31:0];
        OFS_WIN1:  reg_rdata = head_bits[63:32];
        OFS_WIN2:  reg_rdata = {{(96-DESC_W){1'b0}}, head_bits[DESC_W-1:64]};
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_desc_frontend.sv
module dma_desc_frontend
  import dmaq_pkg::*;
#(
  parameter int QAW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                engine_en,
  output logic                dsc_valid,
  input  logic                dsc_ready,
  output logic [DESC_W-1:0]   dsc_data,
  input  logic                cpl_valid,
  output logic                cpl_ready,
  input  logic [DESC_W-1:0]   cpl_data
);
  localparam int NIDX = 1 << IDX_W;

  logic          hold, loop_en, sw_commit, win_pop, loop_push, cpl_take;
  logic          av_full, av_empty, av_push, av_pop;
  logic          cp_full, cp_empty, ovf_q;
  logic [QAW:0]  av_cnt, cpl_cnt;
  desc_t         sw_desc, recyc, av_din, av_head, cp_head, cpl_in;
  logic [CNT_W-1:0] cnt_tab [NIDX];

  assign cpl_in    = desc_t'(cpl_data);
  assign cpl_ready = !hold && !cp_full;
  assign cpl_take  = cpl_valid && cpl_ready;
  assign loop_push = cpl_take && loop_en;

  assign recyc.addr = cpl_in.addr;
  assign recyc.cnt  = cnt_tab[cpl_in.idx];
  assign recyc.idx  = cpl_in.idx;

  assign av_push   = loop_push || sw_commit;
  assign av_din    = loop_push ? recyc : sw_desc;
  assign dsc_valid = engine_en && !av_empty;
  assign av_pop    = dsc_valid && dsc_ready;
  assign dsc_data  = av_head;

  dmaq_csr #(.QAW(QAW)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .loop_push(loop_push), .cpl_head(cp_head), .cpl_empty(cp_empty),
    .cpl_cnt(cpl_cnt), .avail_cnt(av_cnt), .ovf(ovf_q),
    .hold(hold), .run(engine_en), .loop_en(loop_en),
    .sw_desc(sw_desc), .sw_commit(sw_commit), .win_pop(win_pop)
  );

  dmaq_fifo #(.W(DESC_W), .AW(QAW)) u_availq (
    .clk(clk), .rst_n(rst_n), .clr(hold), .push(av_push), .din(av_din),
    .pop(av_pop), .dout(av_head), .full(av_full), .empty(av_empty), .count(av_cnt)
  );

  dmaq_fifo #(.W(DESC_W), .AW(QAW)) u_cplq (
    .clk(clk), .rst_n(rst_n), .clr(hold), .push(cpl_take), .din(cpl_in),
    .pop(win_pop), .dout(cp_head), .full(cp_full), .empty(cp_empty), .count(cpl_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovf_q <= 1'b0;
    else if (hold)               ovf_q <= 1'b0;
    else if (av_push && av_full) ovf_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (sw_commit && !av_full) cnt_tab[sw_desc.idx] <= sw_desc.cnt;
  end
endmodule

// File: rtl/dma_desc_frontend_chk.sv
module dma_desc_frontend_chk #(
  parameter int QAW = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic         hold,
  input logic         ovf,
  input logic [QAW:0] cpl_cnt,
  input logic         engine_en,
  input logic         dsc_valid,
  input logic         dsc_ready,
  input logic [71:0]  dsc_data,
  input logic         cpl_ready
);
  localparam int DEPTH = 1 << QAW;

  a_r4_valid_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> engine_en);

  a_r4_stall_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && !dsc_ready && !reg_wr) |=> (dsc_valid && $stable(dsc_data)));

  a_r1_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!dsc_valid && !cpl_ready && !engine_en));

  a_r1_hold_empties: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cpl_cnt == '0));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !hold) |=> ovf);

  a_r5_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_cnt == DEPTH[QAW:0]) |-> !cpl_ready);
endmodule

bind dma_desc_frontend dma_desc_frontend_chk #(.QAW(QAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .hold(hold), .ovf(ovf_q),
  .cpl_cnt(cpl_cnt), .engine_en(engine_en), .dsc_valid(dsc_valid),
  .dsc_ready(dsc_ready), .dsc_data(dsc_data), .cpl_ready(cpl_ready)
);

// File: tb/dma_desc_frontend_tb.sv
`timescale 1ns/1ps
module dma_desc_frontend_tb;
  localparam int QAW   = 3;
  localparam int DEPTH = 1 << QAW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        engine_en, dsc_valid, cpl_ready;
  logic        dsc_ready = 0, cpl_valid = 0;
  logic [71:0] dsc_data;
  logic [71:0] cpl_data = 0;

  always #4 clk = ~clk;

  dma_desc_frontend #(.QAW(QAW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .engine_en(engine_en), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_data(dsc_data), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_data(cpl_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [71:0] avq[$];
  logic [71:0] cpq[$];
  int          tab[int];
  logic [2:0]  m_rst = 3'b111;
  bit          m_run = 0, m_loop = 0, m_ovf = 0, m_pend = 0;
  logic [31:0] m_w0 = 0, m_w1 = 0;
  logic [71:0] m_pd = 0;

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    logic [71:0] h;
    h = (cpq.size() > 0) ? cpq[0] : 72'd0;
    if (!reg_rd) return 32'd0;
    case (reg_addr)
      8'h00: return {23'd0, m_run, 5'd0, m_rst};
      8'h04: return {31'd0, m_loop};
      8'h10: return cpq.size();
      8'h18: return avq.size();
      8'h1C: return {30'd0, m_ovf, cpq.size() == 0};
      8'h20: return h[31:0];
      8'h24: return h[63:32];
      8'h28: return {24'd0, h[71:64]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (reg_addr)
      8'h00, 8'h04: return "R1 R8 control readback";
      8'h10, 8'h18: return "R7 queue counts";
      8'h1C:        return "R3 R7 flags";
      default:      return "R6 window word";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit hold, xv, xr, acc, lp, com, avfull;
      hold = (m_rst != 0);
      xv = m_run && !hold && avq.size() > 0;
      xr = !hold && cpq.size() < DEPTH;
      chk("R1 engine_en", engine_en, m_run && !hold);
      chk("R4 dsc_valid", dsc_valid, xv);
      if (xv) chk("R2 R8 R9 dsc_data order", dsc_data, avq[0]);
      chk("R5 cpl_ready", cpl_ready, xr);
      chk(rd_tag(), reg_rdata, exp_rdata());
      // next state
      acc = cpl_valid && xr;
      lp  = acc && m_loop;
      com = m_pend && !lp && !hold;
      if (hold) begin
        avq.delete(); cpq.delete(); m_ovf = 0;
      end else begin
        avfull = (avq.size() == DEPTH);
        if (xv && dsc_ready) void'(avq.pop_front());
        if (lp) begin
          if (avfull) m_ovf = 1;
          else avq.push_back({cpl_data[71:32], 23'(tab[int'(cpl_data[8:0])]), cpl_data[8:0]});
        end
        if (com) begin
          if (avfull) m_ovf = 1;
          else begin
            avq.push_back(m_pd);
            tab[int'(m_pd[8:0])] = int'(m_pd[31:9]);
          end
        end
        if (reg_rd && reg_addr == 8'h28 && cpq.size() > 0) void'(cpq.pop_front());
        if (acc) cpq.push_back(cpl_data);
      end
      m_pend = !hold && ((reg_wr && reg_addr == 8'h28) || (m_pend && lp));
      if (reg_wr) begin
        case (reg_addr)
          8'h00: begin m_rst = reg_wdata[2:0]; m_run = reg_wdata[8]; end
          8'h04: m_loop = reg_wdata[0];
          8'h20: m_w0 = reg_wdata;
          8'h24: m_w1 = reg_wdata;
          8'h28: m_pd = {reg_wdata[7:0], m_w1, m_w0};
          default: ;
        endcase
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
  endtask

  task automatic post(int idx, int cnt, logic [39:0] adr);
    wr(8'h20, {cnt[22:0], idx[8:0]});
    wr(8'h24, adr[31:0]);
    wr(8'h28, {24'd0, adr[39:32]});
  endtask

  task automatic cpl(int idx, int cnt, logic [39:0] adr);
    cpl_valid = 1; cpl_data = {adr, cnt[22:0], idx[8:0]};
    tick();
    cpl_valid = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1: held after reset
    rd(8'h00); rd(8'h1C);
    cpl(1, 5, 40'h1);            // refused while held (R1, R5)
    wr(8'h00, 0);
    // R2: commit, R7 counts
    post(3, 4096, 40'hAB_1234_5678);
    post(4, 100, 40'h01_0000_0040);
    post(9, 7, 40'hFF_FFFF_FFF0);
    tick();
    rd(8'h18);
    // R4: enable with back-pressure, then drain
    dsc_ready = 0;
    wr(8'h00, 32'h100);
    tick(3);
    dsc_ready = 1;
    tick(4);
    // R6: completions with a short final count
    cpl(3, 4096, 40'hAB_1234_5678);
    cpl(4, 100, 40'h01_0000_0040);
    cpl(9, 3, 40'hFF_FFFF_FFF0);
    rd(8'h10);
    for (int i = 0; i < 3; i++) begin
      rd(8'h20); rd(8'h24); rd(8'h1C); rd(8'h28);
    end
    rd(8'h28); rd(8'h10); rd(8'h1C);
    // R5: fill completion queue, one more is refused
    for (int i = 0; i < DEPTH + 2; i++) cpl(i, i + 1, 40'(i * 16));
    rd(8'h10);
    wr(8'h00, 7); rd(8'h10); wr(8'h00, 0);
    // R3: overflow of available queue
    dsc_ready = 0;
    for (int i = 0; i < DEPTH + 1; i++) post(20 + i, 64 + i, 40'(i * 256));
    tick();
    rd(8'h18); rd(8'h1C);
    wr(8'h00, 32'h100);
    dsc_ready = 1;
    tick(4);
    rd(8'h1C); rd(8'h18);
    wr(8'h00, 7); rd(8'h1C); wr(8'h00, 0); rd(8'h1C);
    // R8: loop mode recycling
    wr(8'h04, 1); rd(8'h04);
    post(5, 100, 40'h12_0000_1000);
    post(6, 200, 40'h12_0000_2000);
    wr(8'h00, 32'h100);
    tick(3);
    dsc_ready = 0;
    cpl(5, 40, 40'h12_0000_1000);
    tick();
    rd(8'h18); rd(8'h10);
    // R9: same-edge recirculation and software commit
    wr(8'h20, {23'd300, 9'd7});
    wr(8'h24, 32'h0000_3000);
    reg_wr = 1; reg_addr = 8'h28; reg_wdata = 32'h12;
    tick();
    reg_wr = 0;
    cpl_valid = 1; cpl_data = {40'h12_0000_2000, 23'd9, 9'd6};
    tick();
    cpl_valid = 0;
    tick(2);
    rd(8'h18);
    dsc_ready = 1;
    tick(4);
    rd(8'h18);
    tick(2);
    done = 1;
    summary();
    $finish;
  end
endmodule